// File: doc/BRIEF.md
# Tiled 2D DMA Address Generator

This block produces the beat-address stream for one side of a memory-to-memory copy, either the read side or the write side. The region is described as a grid of tiles. Each line is a run of `xn` regular column segments of `xa` bytes, closed by one remainder segment of `xb` bytes. Lines are grouped into `yn` regular bands of `ya+1` lines, followed by one remainder band of `yb+1` lines that is always emitted. The geometry is walked left to right inside a line and top to bottom across lines. Without inter-tile offsets the result is one contiguous stream of addresses starting at a base.

A one-cycle `start` samples the base and the six geometry fields. The block then checks the configuration. A region whose remainder width holds no whole beat is rejected with a one-cycle `error` pulse, and no address is issued for it. A valid region is issued one address per beat over a valid/ready handshake, with per-beat end-of-line and end-of-region flags. A one-cycle `done` pulse follows the final accepted beat. The total byte count of the region is reported on `byte_count`.

The state machine has four states. `ST_IDLE` waits for a start. `ST_CHECK` lasts one cycle: it validates the sampled geometry and loads the counters. `ST_RUN` issues beats. `ST_DONE` lasts one cycle and raises `done`. The transitions are:
- IDLE→CHECK on `start`.
- CHECK→IDLE when the configuration is invalid, raising `error` during CHECK.
- CHECK→RUN when the configuration is valid.
- RUN→DONE when the final beat is accepted.
- DONE→IDLE unconditionally.

Top module: `dma_tile_walker`

## Requirements
- R1: After reset the block is idle: `addr_valid`, `busy`, `done` and `error` are all low.
- R2: The base and geometry inputs are sampled only when `start` is high while `busy` is low. A `start` while busy is ignored and leaves the running transfer unchanged, with no error.
- R3: Each line consists of `xn` regular segments of `xa` bytes followed by one segment of `xb` bytes. When `xn` or `xa` is zero, a line is `xb` bytes. `addr_eol` is high on exactly the final beat of every line.
- R4: The height fields store one less than the real height. There are `yn` regular bands of `ya+1` lines each, then one remainder band of `yb+1` lines. The remainder band is present even when `yb` is 0.
- R5: When `yn` is 0, `ya` has no effect, and the region is exactly `yb+1` lines.
- R6: Widths are counted in whole beats of `BEAT_BYTES` bytes (16 by default). If `xb` holds zero whole beats, which includes `xb`=0, `error` is high for one cycle in the cycle after the start edge. No address is issued in that case, and the block returns to idle.
- R7: Beat k of a transfer carries address base + k·`BEAT_BYTES`, for k counting from 0.
- R8: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr`, `addr_eol` and `addr_last` hold their values.
- R9: `addr_last` is high on exactly the final beat of the region. `done` is high for exactly one cycle, the cycle after that beat is accepted.
- R10: From `done` until the next accepted start, `byte_count` equals (xa·xn + xb)·((ya+1)·yn + yb + 1), with each width taken in whole beats.
- R11: With xa=xb=0x80, xn=15, ya=yb=15 and yn=3, the region is 64 lines of 0x800 bytes, which gives 0x20000 bytes in 8192 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| base | input | ADDR_W | Byte address of the first beat |
| xa | input | WID_W | Regular column segment width in bytes |
| xb | input | WID_W | Remainder column segment width in bytes |
| xn | input | CNT_W | Number of regular column segments per line |
| ya | input | CNT_W | Regular band height minus one |
| yb | input | CNT_W | Remainder band height minus one |
| yn | input | CNT_W | Number of regular bands |
| addr_valid | output | 1 | An address is offered |
| addr_ready | input | 1 | The consumer accepts the offered address |
| addr | output | ADDR_W | Beat byte address |
| addr_eol | output | 1 | The offered beat ends a line |
| addr_last | output | 1 | The offered beat ends the region |
| busy | output | 1 | A transfer is being checked or run |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle invalid-configuration pulse |
| byte_count | output | BC_W | Total bytes of the last accepted region |

## Verification
The bench targets the encoding corners of the geometry.

- A remainder band with `yb`=0 must still yield one line. A design that treated a zero field as "absent" would cut the region short, and the beat count and `addr_last` position would be wrong.
- `yn`=0 with a large `ya` must yield only `yb+1` lines. Letting `ya` leak in would give extra lines and misplaced `addr_eol` flags.
- Lines with `xn`=0, and lines with `xa`=0, must consist of the remainder segment alone. Mishandling either case would stall the walk or skew every end-of-line flag.
- A zero-beat `xb` must give an error pulse and no beats. A start that arrives mid-run must not alter the count.
- Random back-pressure exposes any address or flag that moves while the beat is stalled.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } tw_state_e;
endpackage

// File: rtl/tw_geom.sv
`timescale 1ns/1ps
// Derives beat counts, the region byte total and validity from the latched geometry.
module tw_geom #(
    parameter int WID_W      = 17,
    parameter int CNT_W      = 16,
    parameter int BEAT_BYTES = 16,
    localparam int SH   = $clog2(BEAT_BYTES),
    localparam int LB_W = WID_W + CNT_W + 1,
    localparam int LN_W = 2 * CNT_W + 2,
    localparam int BC_W = LB_W + LN_W
) (
    input  logic [WID_W-1:0] xa,
    input  logic [WID_W-1:0] xb,
    input  logic [CNT_W-1:0] xn,
    input  logic [CNT_W-1:0] ya,
    input  logic [CNT_W-1:0] yb,
    input  logic [CNT_W-1:0] yn,
    output logic [WID_W-1:0] xa_beats,
    output logic [WID_W-1:0] xb_beats,
    output logic [BC_W-1:0]  byte_total,
    output logic             bad
);
    logic [LB_W-1:0] line_beats;
    logic [LN_W-1:0] lines;

    always_comb begin
        xa_beats   = xa >> SH;
        xb_beats   = xb >> SH;
        line_beats = LB_W'(xa_beats) * LB_W'(xn) + LB_W'(xb_beats);
        // R4/R5: heights stored minus one; a zero yn removes ya from the product
        lines      = (LN_W'(ya) + LN_W'(1)) * LN_W'(yn) + LN_W'(yb) + LN_W'(1);
        byte_total = (BC_W'(line_beats) * BC_W'(lines)) << SH;
        // R6: a remainder segment with no whole beat is rejected
        bad        = (xb_beats == '0);
    end
endmodule

// File: rtl/tw_line_ctr.sv
`timescale 1ns/1ps
// Walks the column segments of one line; flags the final beat of the line.
module tw_line_ctr #(
    parameter int WID_W = 17,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WID_W-1:0] xa_beats,
    input  logic [WID_W-1:0] xb_beats,
    input  logic [CNT_W-1:0] xn,
    output logic             eol
);
    logic [CNT_W-1:0] seg_q;
    logic [WID_W-1:0] beat_q;
    logic             rem_q;
    logic             rem_first;
    logic [WID_W-1:0] seg_len;
    logic             seg_end;

    always_comb begin
        // R3: no regular segments when either count or width is zero
        rem_first = (xn == '0) || (xa_beats == '0);
        seg_len   = rem_q ? xb_beats : xa_beats;
        seg_end   = (beat_q == seg_len - WID_W'(1));
        eol       = rem_q && seg_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q  <= '0;
            beat_q <= '0;
            rem_q  <= 1'b0;
        end else if (load) begin
            seg_q  <= '0;
            beat_q <= '0;
            rem_q  <= rem_first;
        end else if (step) begin
            if (!seg_end) begin
                beat_q <= beat_q + WID_W'(1);
            end else begin
                beat_q <= '0;
                if (rem_q) begin
                    seg_q <= '0;
                    rem_q <= rem_first;
                end else if (seg_q == xn - CNT_W'(1)) begin
                    rem_q <= 1'b1;
                end else begin
                    seg_q <= seg_q + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/tw_row_ctr.sv
`timescale 1ns/1ps
// Walks the row bands; flags the final line of the region.
module tw_row_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] ya,
    input  logic [CNT_W-1:0] yb,
    input  logic [CNT_W-1:0] yn,
    output logic             last_line
);
    logic [CNT_W-1:0] band_q;
    logic [CNT_W-1:0] line_q;
    logic             rem_q;
    logic [CNT_W-1:0] h_m1;
    logic             band_end;

    always_comb begin
        h_m1      = rem_q ? yb : ya;
        band_end  = (line_q == h_m1);
        // R4: the remainder band always closes the region
        last_line = rem_q && band_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            band_q <= '0;
            line_q <= '0;
            rem_q  <= 1'b0;
        end else if (load) begin
            band_q <= '0;
            line_q <= '0;
            rem_q  <= (yn == '0);       // R5: skip regular bands entirely
        end else if (step) begin
            if (!band_end) begin
                line_q <= line_q + CNT_W'(1);
            end else begin
                line_q <= '0;
                if (!rem_q) begin
                    if (band_q == yn - CNT_W'(1)) begin
                        rem_q <= 1'b1;
                    end else begin
                        band_q <= band_q + CNT_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dma_tile_walker.sv
`timescale 1ns/1ps
module dma_tile_walker
    import tw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WID_W      = 17,
    parameter int CNT_W      = 16,
    parameter int BEAT_BYTES = 16,
    localparam int BC_W = (WID_W + CNT_W + 1) + (2 * CNT_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [WID_W-1:0]  xa,
    input  logic [WID_W-1:0]  xb,
    input  logic [CNT_W-1:0]  xn,
    input  logic [CNT_W-1:0]  ya,
    input  logic [CNT_W-1:0]  yb,
    input  logic [CNT_W-1:0]  yn,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_eol,
    output logic              addr_last,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [BC_W-1:0]   byte_count
);
    tw_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q, addr_q;
    logic [WID_W-1:0]  xa_q, xb_q, xa_beats, xb_beats;
    logic [CNT_W-1:0]  xn_q, ya_q, yb_q, yn_q;
    logic [BC_W-1:0]   total_bytes, bytes_q;
    logic              bad, eol, last_line, accept, take_cfg, in_check;

    assign take_cfg = start && (state_q == ST_IDLE);   // R2
    assign in_check = (state_q == ST_CHECK);
    assign accept   = (state_q == ST_RUN) && addr_ready;

    tw_geom #(.WID_W(WID_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)) u_geom (
        .xa(xa_q), .xb(xb_q), .xn(xn_q), .ya(ya_q), .yb(yb_q), .yn(yn_q),
        .xa_beats(xa_beats), .xb_beats(xb_beats),
        .byte_total(total_bytes), .bad(bad)
    );

    tw_line_ctr #(.WID_W(WID_W), .CNT_W(CNT_W)) u_line (
        .clk(clk), .rst_n(rst_n), .load(in_check), .step(accept),
        .xa_beats(xa_beats), .xb_beats(xb_beats), .xn(xn_q), .eol(eol)
    );

    tw_row_ctr #(.CNT_W(CNT_W)) u_row (
        .clk(clk), .rst_n(rst_n), .load(in_check), .step(accept && eol),
        .ya(ya_q), .yb(yb_q), .yn(yn_q), .last_line(last_line)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CHECK;
            ST_CHECK: state_d = bad ? ST_IDLE : ST_RUN;          // R6
            ST_RUN:   if (addr_ready && eol && last_line) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        addr_valid = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        error      = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy       = 1'b0;
            ST_CHECK: error      = bad;
            ST_RUN:   addr_valid = 1'b1;
            ST_DONE:  done       = 1'b1;
            default:  busy       = 1'b0;
        endcase
        addr       = addr_q;
        addr_eol   = addr_valid && eol;
        addr_last  = addr_valid && eol && last_line;
        byte_count = bytes_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            addr_q  <= '0;
            bytes_q <= '0;
            xa_q    <= '0;
            xb_q    <= '0;
            xn_q    <= '0;
            ya_q    <= '0;
            yb_q    <= '0;
            yn_q    <= '0;
        end else begin
            if (take_cfg) begin
                base_q <= base;
                xa_q   <= xa;
                xb_q   <= xb;
                xn_q   <= xn;
                ya_q   <= ya;
                yb_q   <= yb;
                yn_q   <= yn;
            end
            if (in_check) begin
                addr_q <= base_q;
                if (!bad) bytes_q <= total_bytes;                // R10
            end else if (accept) begin
                addr_q <= addr_q + ADDR_W'(BEAT_BYTES);          // R7
            end
        end
    end
endmodule

// File: rtl/tw_chk.sv
`timescale 1ns/1ps
module tw_chk #(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_valid,
    input logic              addr_ready,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_eol,
    input logic              addr_last,
    input logic              busy,
    input logic              done,
    input logic              error
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr) && $stable(addr_eol) && $stable(addr_last)));

    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_ready && !addr_last) |=> (addr_valid && addr == $past(addr) + ADDR_W'(BEAT_BYTES)));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_ready && addr_last) |=> (done && !addr_valid));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_error_no_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !addr_valid);

    assert_error_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (!error && !busy));

    assert_valid_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> busy);

    assert_eol_with_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_eol);
endmodule

bind dma_tile_walker tw_chk #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_tw_chk (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr(addr), .addr_eol(addr_eol), .addr_last(addr_last),
    .busy(busy), .done(done), .error(error)
);

// File: tb/sim_dma_tile_walker.sv
`timescale 1ns/1ps
module sim_dma_tile_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic [16:0] xa = '0, xb = '0;
    logic [15:0] xn = '0, ya = '0, yb = '0, yn = '0;
    logic        addr_valid, addr_ready = 1'b0;
    logic [31:0] addr;
    logic        addr_eol, addr_last, busy, done, error;
    logic [67:0] byte_count;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dma_tile_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base),
        .xa(xa), .xb(xb), .xn(xn), .ya(ya), .yb(yb), .yn(yn),
        .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
        .addr_eol(addr_eol), .addr_last(addr_last), .busy(busy),
        .done(done), .error(error), .byte_count(byte_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(!addr_valid && !busy && !done && !error, "R1", "idle after reset",
            {addr_valid, busy, done, error}, 0);
    endtask

    // One transfer; lb = beats per line, ln = lines, both worked out by hand.
    task automatic run_xfer(input logic [31:0] b, input logic [16:0] a, input logic [16:0] bx,
                            input logic [15:0] n, input logic [15:0] ha, input logic [15:0] hb,
                            input logic [15:0] nb, input int rmode, input int lb, input int ln,
                            input bit inject, input string tg);
        int total = lb * ln;
        int nacc = 0, cyc = 0;
        int addr_bad = 0, eol_bad = 0, last_bad = 0, hold_bad = 0, done_bad = 0, err_seen = 0;
        bit done_seen = 0, prev_last = 0, stalled = 0, inj = 0, r;
        logic [31:0] prev_ad = '0;
        @(negedge clk);
        base = b; xa = a; xb = bx; xn = n; ya = ha; yb = hb; yn = nb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!error && busy, "R6", {tg, " no error on valid start"}, error, 0);
        while (!done_seen && cyc < 50000) begin
            @(negedge clk);
            cyc++;
            if (error) err_seen++;
            if (stalled && (!addr_valid || addr != prev_ad)) hold_bad++;
            if (done) begin
                done_seen = 1;
                if (!prev_last) done_bad++;
            end
            case (rmode)
                0: r = 1'b1;
                1: r = (cyc % 3) != 0;
                default: r = (cyc % 5) < 2;
            endcase
            addr_ready = r;
            if (start) start = 1'b0;
            else if (inject && !inj && nacc == 10) begin
                // R2: a start while busy with a different geometry
                start = 1'b1; xb = 17'd0; xn = 16'd7; yn = 16'd9; base = 32'hdead0000;
                inj = 1;
            end
            prev_last = 0;
            stalled = addr_valid && !r;
            prev_ad = addr;
            if (addr_valid && r) begin
                if (addr != b + 32'(nacc * 16)) addr_bad++;
                if (addr_eol != (((nacc + 1) % lb) == 0)) eol_bad++;
                if (addr_last != (nacc + 1 == total)) last_bad++;
                if (addr_last) prev_last = 1;
                nacc++;
            end
        end
        addr_ready = 1'b0;
        start = 1'b0;
        chk(nacc == total, "R4", {tg, " beat count"}, nacc, total);
        chk(addr_bad == 0, "R7", {tg, " contiguous addresses"}, addr_bad, 0);
        chk(eol_bad == 0, "R3", {tg, " end-of-line flags"}, eol_bad, 0);
        chk(last_bad == 0, "R9", {tg, " last flag"}, last_bad, 0);
        chk(done_seen && done_bad == 0, "R9", {tg, " done after last accept"}, done_bad, 0);
        chk(hold_bad == 0, "R8", {tg, " stall stability"}, hold_bad, 0);
        chk(byte_count == 68'(total * 16), "R10", {tg, " byte count"},
            longint'(byte_count), longint'(total * 16));
        if (inject) chk(err_seen == 0 && inj, "R2", {tg, " busy start ignored"}, err_seen, 0);
        @(negedge clk);
        chk(!done && !busy, "R9", {tg, " done one cycle"}, {done, busy}, 0);
    endtask

    task automatic t_bad(input logic [16:0] bx, input string tg);
        int vseen = 0;
        @(negedge clk);
        xa = 17'h40; xb = bx; xn = 16'd2; ya = 16'd1; yb = 16'd1; yn = 16'd1; start = 1'b1;
        addr_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(error == 1'b1, "R6", {tg, " error pulse in cycle after start"}, error, 1);
        if (addr_valid) vseen++;
        @(negedge clk);
        chk(!error && !busy, "R6", {tg, " error one cycle then idle"}, {error, busy}, 0);
        for (int i = 0; i < 5; i++) begin
            if (addr_valid) vseen++;
            @(negedge clk);
        end
        chk(vseen == 0, "R6", {tg, " no addresses issued"}, vseen, 0);
        addr_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R11: 16 beats x 8 per line... 128 beats/line, 64 lines, 0x20000 bytes
        run_xfer(32'h1000_0000, 17'h80, 17'h80, 16'd15, 16'd15, 16'd15, 16'd3, 0, 128, 64, 0, "R11 example");
        // R3 R4 R8: 2-beat regular x3 + 3-beat remainder; 2 bands of 2 + 1 line; back-pressure
        run_xfer(32'h0000_4000, 17'h20, 17'h30, 16'd3, 16'd1, 16'd0, 16'd2, 1, 9, 5, 0, "R3 mixed");
        // R5: yn=0 with ya=7 ignored; xn=0 gives remainder-only lines
        run_xfer(32'h0002_0000, 17'h40, 17'h10, 16'd0, 16'd7, 16'd2, 16'd0, 2, 1, 3, 0, "R5 yn zero");
        // R3: xa=0 with xn=5; R4: yb=0 remainder band still one line
        run_xfer(32'h0003_0000, 17'h00, 17'h20, 16'd5, 16'd0, 16'd0, 16'd1, 1, 2, 2, 0, "R4 yb zero");
        // R6: zero and sub-beat remainder widths
        t_bad(17'h0, "R6 xb zero");
        t_bad(17'h8, "R6 xb sub-beat");
        // R2: start while busy ignored
        run_xfer(32'h0005_0000, 17'h20, 17'h30, 16'd3, 16'd1, 16'd0, 16'd2, 2, 9, 5, 1, "R2 busy start");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule